// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The block turns general-purpose pin activity into interrupt requests for sixteen lines. Each line looks at the pin with its own number on one of several ports. A per-line select field picks the port. The chosen signal passes through a two-stage synchronizer. The block then compares it with its value one cycle earlier to find edges.

A line can be armed for rising edges, falling edges or both. An armed edge sets a sticky pending flag. Software clears the flag by writing a 1 to its bit. A pending flag drives the line's request output only while the line is unmasked, so a request stays up until software acknowledges it.

Configuration goes through a simple register port. It has a write strobe, an address and data for writes, and a separate read address with combinational read data. Global enables and vectoring belong to the processor side and are not part of this block.

Top module: `ext_edge_irq`

## Requirements
- R1: Line i has a 4-bit select field in register i/4 (addresses 0 to 3), at bits (i%4)*4+3 down to (i%4)*4. A field value p below NPORTS (default 4) routes pin p*16+i of the `pins` bus onto line i, and value 0 selects port A (pins 15..0).
- R2: `irq[i]` is high exactly when pending bit i is set and mask bit i (address 4) is 1. With a mask bit of 0 the request stays low.
- R3: When rise bit i (address 5) is 1, a low-to-high change of the selected pin sets pending bit i. The flag is visible at the third rising clock edge after the pin changes: two synchronizer stages, then the pending register.
- R4: When fall bit i (address 6) is 1, a high-to-low change sets pending bit i with the same latency. With both bits set, either edge sets it. With neither set, no edge sets it.
- R5: Pending bits (address 7) hold until a write to address 7 with a 1 in that bit position clears them. A 0 written to a bit leaves that bit unchanged.
- R6: If an armed edge and a clear of the same bit happen in the same cycle, the pending bit ends up set.
- R7: Select values from NPORTS to 15 route a constant 0, so pins on any port cause no edge on that line.
- R8: After reset every register reads 0, all lines are masked with no trigger enabled, and `irq` is 0.
- R9: Mask, rise, fall and pending registers use data bits 15..0, and select registers use bits 15..0. Unused upper bits read as 0, and a written value reads back on `rd_data` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | 64 | Pin values of all ports, port p at bits p*16+15..p*16 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| irq | output | 16 | Per-line interrupt request |

## Verification
The assertions assume that every input carries a known 0 or 1 at each clock edge. They also assume that a write which changes the mask or clears a pending bit is the only thing allowed to drop a request. The bench drives pins, writes and addresses from `$urandom` only on falling clock edges, so every value is defined when the design samples it. A cycle model in the bench predicts every pending bit and request. Random select values cover unused port codes, and directed sequences place a clear in the exact cycle of an edge.

// File: rtl/ext_edge_irq.sv
module ext_edge_irq #(
  parameter int LINES  = 16,
  parameter int NPORTS = 4,
  parameter int SELW   = 4,
  parameter int DW     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*LINES-1:0]  pins,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [2:0]               rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic [LINES-1:0]         irq
);
  localparam int PER_REG  = 4;
  localparam int SEL_REGS = LINES / PER_REG;
  localparam logic [2:0] A_MASK = 3'(SEL_REGS);
  localparam logic [2:0] A_RISE = 3'(SEL_REGS + 1);
  localparam logic [2:0] A_FALL = 3'(SEL_REGS + 2);
  localparam logic [2:0] A_PEND = 3'(SEL_REGS + 3);

  logic [NPORTS*LINES-1:0] s1, s2;
  logic [LINES-1:0] mask, rise, fall, pend, prev, cur, hit, clr;
  logic [SELW-1:0] sel [LINES];

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      cur[i] = 1'b0;
      for (int p = 0; p < NPORTS; p++)
        if (sel[i] == SELW'(p)) cur[i] = s2[p*LINES+i];
    end
  end

  assign hit = (rise & cur & ~prev) | (fall & ~cur & prev);
  assign clr = (wr_en && wr_addr == A_PEND) ? wr_data[LINES-1:0] : '0;
  assign irq = pend & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0; pend <= '0;
      mask <= '0; rise <= '0; fall <= '0;
      for (int i = 0; i < LINES; i++) sel[i] <= '0;
    end else begin
      s1   <= pins;
      s2   <= s1;
      prev <= cur;
      pend <= (pend & ~clr) | hit;
      if (wr_en) begin
        if (wr_addr == A_MASK) mask <= wr_data[LINES-1:0];
        if (wr_addr == A_RISE) rise <= wr_data[LINES-1:0];
        if (wr_addr == A_FALL) fall <= wr_data[LINES-1:0];
        for (int i = 0; i < LINES; i++)
          if (wr_addr == 3'(i / PER_REG))
            sel[i] <= wr_data[(i%PER_REG)*SELW +: SELW];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_MASK)      rd_data[LINES-1:0] = mask;
    else if (rd_addr == A_RISE) rd_data[LINES-1:0] = rise;
    else if (rd_addr == A_FALL) rd_data[LINES-1:0] = fall;
    else if (rd_addr == A_PEND) rd_data[LINES-1:0] = pend;
    else
      for (int i = 0; i < LINES; i++)
        if (rd_addr == 3'(i / PER_REG))
          rd_data[(i%PER_REG)*SELW +: SELW] = sel[i];
  end

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (irq == '0)); // R2
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_PEND) |=> ((pend & $past(pend)) == $past(pend))); // R5
  AST_NEW_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(rise | fall)) == '0)); // R4
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == A_MASK || wr_addr == A_PEND)) |=> ((irq & $past(irq)) == $past(irq))); // R2
endmodule

// File: tb/tb_ext_edge_irq.sv
`timescale 1ns/1ps
module tb_ext_edge_irq;
  logic clk = 0, rst_n = 0;
  logic [63:0] pins = '0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = 3'd7;
  logic [31:0] wr_data = '0, rd_data;
  logic [15:0] irq;
  int total = 0, bad = 0;
  bit chk_on = 0;

  ext_edge_irq dut (.clk, .rst_n, .pins, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .irq);

  always #5 clk = ~clk;

  // cycle model built from the requirements
  logic [63:0] m_s1 = '0, m_s2 = '0;
  logic [15:0] m_mask = '0, m_rise = '0, m_fall = '0, m_pend = '0, m_prev = '0;
  logic [3:0]  m_sel [16];

  function automatic logic line_of(logic [3:0] s, logic [63:0] v, int i);
    return (s < 4) ? v[s*16+i] : 1'b0;
  endfunction

  always @(posedge clk) begin
    logic [15:0] c, h, cl;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0;
      m_mask = '0; m_rise = '0; m_fall = '0;
      for (int i = 0; i < 16; i++) m_sel[i] = '0;
    end else begin
      for (int i = 0; i < 16; i++) c[i] = line_of(m_sel[i], m_s2, i);
      h  = (m_rise & c & ~m_prev) | (m_fall & ~c & m_prev);
      cl = (wr_en && wr_addr == 3'd7) ? wr_data[15:0] : '0;
      m_pend = (m_pend & ~cl) | h;
      m_prev = c;
      m_s2 = m_s1; m_s1 = pins;
      if (wr_en) begin
        if (wr_addr == 3'd4) m_mask = wr_data[15:0];
        if (wr_addr == 3'd5) m_rise = wr_data[15:0];
        if (wr_addr == 3'd6) m_fall = wr_data[15:0];
        if (wr_addr < 3'd4)
          for (int k = 0; k < 4; k++) m_sel[wr_addr*4+k] = wr_data[k*4 +: 4];
      end
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && chk_on) begin
    check("R2 irq vs model", {16'h0, irq}, {16'h0, m_pend & m_mask});
    if (rd_addr == 3'd7) check("R5 pending vs model", rd_data, {16'h0, m_pend});
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    tick(2); rst_n = 1; tick(2);
    // R8 reset state
    check("R8 irq after reset", {16'h0, irq}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      check("R8 register reset", rd_data, 32'h0);
    end
    // R9 readback and upper bits
    wr(3'd4, 32'hFFFF_A5A5); rd_addr = 3'd4; #1;
    check("R9 mask readback", rd_data, 32'h0000_A5A5);
    wr(3'd1, 32'h1234_9876); rd_addr = 3'd1; #1;
    check("R9 select readback", rd_data, 32'h0000_9876);
    wr(3'd1, 32'h0); wr(3'd4, 32'h0);
    rd_addr = 3'd7; chk_on = 1;

    // R1/R3: line 3 on port 2, rising only
    wr(3'd0, 32'h0000_2000); wr(3'd5, 32'h0008); wr(3'd4, 32'h0008); tick(3);
    pins[2*16+3] = 1'b1;
    tick(2); check("R3 not yet pending", {31'h0, irq[3]}, 32'h0);
    tick();  check("R3 R1 pending after third edge", {31'h0, irq[3]}, 32'h1);
    // R5: writing 0 keeps, writing 1 clears
    wr(3'd7, 32'h0000_FFF7); check("R5 zero write keeps", {31'h0, irq[3]}, 32'h1);
    wr(3'd7, 32'h0000_0008); check("R5 one write clears", {31'h0, irq[3]}, 32'h0);
    // R4 falling not armed: no set
    pins[2*16+3] = 1'b0; tick(4);
    check("R4 disarmed fall ignored", {31'h0, irq[3]}, 32'h0);
    // R4 falling armed
    wr(3'd6, 32'h0008); pins[2*16+3] = 1'b1; tick(4); wr(3'd7, 32'h8); tick(2);
    pins[2*16+3] = 1'b0; tick(3);
    check("R4 falling edge sets", {31'h0, irq[3]}, 32'h1);
    wr(3'd7, 32'h8); tick(2);
    // R6: edge lands in same cycle as clear
    wr(3'd7, 32'h8);
    pins[2*16+3] = 1'b1; tick(2);
    wr_en = 1; wr_addr = 3'd7; wr_data = 32'h8; tick(); wr_en = 0;
    check("R6 edge beats clear", {31'h0, irq[3]}, 32'h1);
    // R2: masked line gives no request but pending readback shows it
    wr(3'd4, 32'h0); check("R2 masked request low", {31'h0, irq[3]}, 32'h0);
    check("R2 pending still held", {31'h0, rd_data[3]}, 32'h1);
    // R7: unused select code
    wr(3'd7, 32'hFFFF); wr(3'd0, 32'h0000_0009); wr(3'd5, 32'h0001); wr(3'd6, 32'h0001);
    wr(3'd4, 32'h0001); tick(3);
    for (int t = 0; t < 4; t++) begin
      pins = {4{16'h0001}} ^ pins; tick(2);
    end
    tick(3); check("R7 unused select quiet", {31'h0, irq[0]}, 32'h0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      pins = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1; wr_addr = 3'($urandom_range(0, 7)); wr_data = $urandom;
      end else wr_en = 0;
      tick();
    end
    wr_en = 0; tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule